// File: doc/BRIEF.md
# Stand-Alone Power-Up Sequencer with Control-Port Takeover

This block runs the start-up sequence of a converter that can come up without a host. Once reset is released it counts audio frame-clock periods; the sequence ends after a number of frames that depends on the chosen speed mode. While the sequence is still counting, the shared configuration pins act as strap inputs.

A host can take over at any moment after reset by writing the control-port-enable bit. That write stops the count, produces a one-cycle strobe that loads the control registers with their defaults, and gives the shared pins to the control port for good.

If the write arrives after the sequence has already finished, the defaults are still loaded and a late-enable flag is raised. A late takeover can cause audible artifacts, so the flag tells the host that the takeover came too late.

The frame clock arrives asynchronously. It passes through a synchronizer into the system clock domain, and only its rising edges are counted. The block has no data stream, so every pin is a plain level or a single-cycle pulse.

Top module: `pwrup_seq_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `seq_done`, `pins_ctl`, `dflt_load` and `late_en` are all 0.
- R2: With `speed_sel` = 2'b00 (single speed), `seq_done` stays 0 until `SS_FRAMES` rising edges of `lrck` have been counted. It goes to 1 within `SYNC_STAGES`+2 clock cycles after that last edge.
- R3: With `speed_sel` = 2'b01 (double speed), the sequence takes 2×`SS_FRAMES` rising edges of `lrck`.
- R4: With `speed_sel` = 2'b10 or 2'b11 (quad speed), the sequence takes 4×`SS_FRAMES` rising edges of `lrck`.
- R5: `speed_sel` is sampled in the first clock cycle after reset is released. Later changes to it do not alter the length of the sequence.
- R6: A `cpen_wr` pulse accepted before the sequence completes stops it. `pins_ctl` is 1 in the following cycle, and `seq_done` stays 0 however many further frames arrive.
- R7: Every accepted `cpen_wr` gives `dflt_load` = 1 for exactly the one cycle after the write. That cycle is the same cycle in which `pins_ctl` first reads 1.
- R8: A `cpen_wr` pulse after completion loads the defaults through R7, sets `late_en` to 1, and leaves `seq_done` at 1. A takeover before completion leaves `late_en` at 0.
- R9: A `cpen_wr` pulse that arrives while `pins_ctl` is already 1 is ignored: no `dflt_load` strobe follows it.
- R10: `seq_done`, `pins_ctl` and `late_en` do not fall again until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Audio frame clock, asynchronous to `clk` |
| speed_sel | input | 2 | Speed mode: 00 single, 01 double, 1x quad |
| cpen_wr | input | 1 | One-cycle pulse: a write set the control-port-enable bit |
| seq_done | output | 1 | Stand-alone sequence ran to completion |
| pins_ctl | output | 1 | Shared pins belong to the control port |
| dflt_load | output | 1 | One-cycle strobe: load control-register defaults |
| late_en | output | 1 | Control port was enabled after completion |

## Verification
The bench builds the block with `SS_FRAMES` = 8 and `SYNC_STAGES` = 2. A full sequence is then 8, 16 or 32 frames, which is short enough to reach completion in every speed mode many times over. The same setting makes it cheap to abort at any frame position, including the frame just before the last one. Frame-clock high and low times are drawn at random, down to three clock cycles, and the bench checks the count both one frame short of the target and exactly at it.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [1:0] {
    PH_ARM     = 2'd0,
    PH_RUN     = 2'd1,
    PH_SA_DONE = 2'd2,
    PH_CTL     = 2'd3
  } phase_e;

  // log2 of the frame multiplier for a speed-mode code
  function automatic logic [1:0] speed_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   speed_shift = 2'd0;
      2'b01:   speed_shift = 2'd1;
      default: speed_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/lrck_edge_sync.sv
module lrck_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck_async,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= lrck_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int SS_FRAMES = 512,
  parameter int CNT_W     = $clog2(4 * SS_FRAMES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [1:0] shift_i,
  input  logic       tick_i,
  output logic       last_o
);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(SS_FRAMES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;

  assign target = BASE << shift_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && tick_i && (cnt_q == target - 1'b1);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwrup_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_i,
  input  logic       cpen_i,
  input  logic       last_i,
  output logic       run_o,
  output logic [1:0] shift_o,
  output logic       seq_done_o,
  output logic       pins_ctl_o,
  output logic       dflt_load_o,
  output logic       late_en_o
);
  phase_e     phase_q;
  logic [1:0] shift_q;
  logic       done_q, load_q, late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ARM;
      shift_q <= 2'd0;
      done_q  <= 1'b0;
      load_q  <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      case (phase_q)
        PH_ARM: begin
          shift_q <= speed_shift(speed_i);
          if (cpen_i) begin
            phase_q <= PH_CTL;
            load_q  <= 1'b1;
          end else begin
            phase_q <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (cpen_i) begin
            phase_q <= PH_CTL;
            load_q  <= 1'b1;
          end else if (last_i) begin
            phase_q <= PH_SA_DONE;
            done_q  <= 1'b1;
          end
        end
        PH_SA_DONE: begin
          if (cpen_i) begin
            phase_q <= PH_CTL;
            load_q  <= 1'b1;
            late_q  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign run_o       = (phase_q == PH_RUN);
  assign shift_o     = shift_q;
  assign seq_done_o  = done_q;
  assign pins_ctl_o  = (phase_q == PH_CTL);
  assign dflt_load_o = load_q;
  assign late_en_o   = late_q;
endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl #(
  parameter int SS_FRAMES   = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck,
  input  logic [1:0] speed_sel,
  input  logic       cpen_wr,
  output logic       seq_done,
  output logic       pins_ctl,
  output logic       dflt_load,
  output logic       late_en
);
  localparam int CNT_W = $clog2(4 * SS_FRAMES + 1);

  logic       rise, run, last;
  logic [1:0] shift;

  lrck_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lrck_async(lrck), .rise_o(rise)
  );

  frame_counter #(.SS_FRAMES(SS_FRAMES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .shift_i(shift),
    .tick_i(rise), .last_o(last)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .speed_i(speed_sel), .cpen_i(cpen_wr),
    .last_i(last), .run_o(run), .shift_o(shift), .seq_done_o(seq_done),
    .pins_ctl_o(pins_ctl), .dflt_load_o(dflt_load), .late_en_o(late_en)
  );
endmodule

// File: rtl/pwrup_seq_checker.sv
module pwrup_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic cpen_wr,
  input logic seq_done,
  input logic pins_ctl,
  input logic dflt_load,
  input logic late_en
);
  // R10: status levels never fall until reset
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> seq_done);
  a_r10_pins_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pins_ctl |=> pins_ctl);
  // R6: a halted sequence never completes afterwards
  a_r6_no_done_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_ctl && !seq_done) |=> !seq_done);
  // R7: strobe is a single cycle, follows a write, and marks the handover
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_load |=> !dflt_load);
  a_r7_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_load |-> ($past(cpen_wr) && pins_ctl && !$past(pins_ctl)));
  // R8: late flag only after a completed sequence and a handover
  a_r8_late_implies: assert property (@(posedge clk) disable iff (!rst_n)
    late_en |-> (seq_done && pins_ctl));
  // R9: no strobe once the pins already belong to the control port
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pins_ctl) |-> !dflt_load);
endmodule

bind pwrup_seq_ctrl pwrup_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpen_wr(cpen_wr), .seq_done(seq_done),
  .pins_ctl(pins_ctl), .dflt_load(dflt_load), .late_en(late_en)
);

// File: tb/pwrup_seq_ctrl_bench.sv
module pwrup_seq_ctrl_bench;
  localparam int SSF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic [1:0] speed_sel = 2'b00;
  logic       cpen_wr = 1'b0;
  logic       seq_done, pins_ctl, dflt_load, late_en;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwrup_seq_ctrl #(.SS_FRAMES(SSF), .SYNC_STAGES(2)) u_pwrup_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .speed_sel(speed_sel),
    .cpen_wr(cpen_wr), .seq_done(seq_done), .pins_ctl(pins_ctl),
    .dflt_load(dflt_load), .late_en(late_en)
  );

  function automatic int frames_for(input logic [1:0] s);
    case (s)
      2'b00:   return SSF;
      2'b01:   return 2 * SSF;
      default: return 4 * SSF;
    endcase
  endfunction

  function automatic string tag_for(input logic [1:0] s);
    case (s)
      2'b00:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      lrck = 1'b1;
      repeat (3 + ($urandom % 6)) @(negedge clk);
      lrck = 1'b0;
      repeat (3 + ($urandom % 6)) @(negedge clk);
    end
  endtask

  task automatic cpen_pulse();
    cpen_wr = 1'b1;
    @(negedge clk);
    cpen_wr = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0;
    lrck = 1'b0;
    cpen_wr = 1'b0;
    speed_sel = s;
    repeat (3) @(negedge clk);
    check("R1 seq_done in reset", seq_done, 1'b0);
    check("R1 pins_ctl in reset", pins_ctl, 1'b0);
    check("R1 dflt_load in reset", dflt_load, 1'b0);
    check("R1 late_en in reset", late_en, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: change the mode after it has been sampled
    speed_sel = s ^ 2'(1 + ($urandom % 3));
    check("R1 seq_done after reset", seq_done, 1'b0);
  endtask

  // abort_at < 0: run to completion; then optionally take over late
  task automatic run_case(input logic [1:0] s, input int abort_at, input bit late);
    int tot = frames_for(s);
    string t = tag_for(s);
    do_reset(s);
    if (abort_at >= 0) begin
      frames(abort_at);
      check({t, " R5 not done before takeover"}, seq_done, 1'b0);
      cpen_pulse();
      check("R6 pins_ctl after early write", pins_ctl, 1'b1);
      check("R7 dflt_load strobe", dflt_load, 1'b1);
      @(negedge clk);
      check("R7 dflt_load single cycle", dflt_load, 1'b0);
      frames(tot - abort_at + 2);
      check("R6 seq_done stays low after halt", seq_done, 1'b0);
      check("R8 late_en low on early takeover", late_en, 1'b0);
      check("R10 pins_ctl held", pins_ctl, 1'b1);
    end else begin
      frames(tot - 1);
      check({t, " R5 not done one frame short"}, seq_done, 1'b0);
      frames(1);
      check({t, " R5 done at frame count"}, seq_done, 1'b1);
      check("R1 pins_ctl low in stand-alone", pins_ctl, 1'b0);
      if (late) begin
        cpen_pulse();
        check("R8 dflt_load on late write", dflt_load, 1'b1);
        check("R8 late_en set", late_en, 1'b1);
        check("R8 seq_done kept", seq_done, 1'b1);
        check("R8 pins_ctl set", pins_ctl, 1'b1);
        @(negedge clk);
        check("R7 dflt_load single cycle (late)", dflt_load, 1'b0);
        cpen_pulse();
        check("R9 second write ignored", dflt_load, 1'b0);
        @(negedge clk);
        check("R9 no delayed strobe", dflt_load, 1'b0);
        frames(2);
        check("R10 late_en held", late_en, 1'b1);
        check("R10 pins_ctl held", pins_ctl, 1'b1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // directed corners
    run_case(2'b00, -1, 1'b1);
    run_case(2'b01, -1, 1'b1);
    run_case(2'b10, -1, 1'b0);
    run_case(2'b11, -1, 1'b1);
    run_case(2'b00, 0, 1'b0);
    run_case(2'b10, 4 * SSF - 1, 1'b0);
    // write in the very first cycle after reset release
    do_reset(2'b01);
    cpen_pulse();
    check("R7 strobe on immediate write", dflt_load, 1'b1);
    frames(2 * SSF + 1);
    check("R6 no completion after immediate write", seq_done, 1'b0);
    // constrained random mix
    for (int k = 0; k < 20; k++) begin
      logic [1:0] s = 2'($urandom % 4);
      if ($urandom % 2) run_case(s, int'($urandom % frames_for(s)), 1'b0);
      else              run_case(s, -1, 1'($urandom % 2));
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule